// File: doc/BRIEF.md
# Abstract Command Register-Transfer Engine

This block runs the abstract commands that an external debugger writes into a debug module's command register. A register-access command can copy a 32-bit value from data register 0 into a hart register chosen by number, or copy a hart register into data register 0. It can then start the program buffer, so that a single command both loads a working register and runs a short instruction sequence that uses it. When the command has no transfer and only the post-execution flag, the buffer runs on its own.

Toward the hart the block drives a register-file style request that is held until the hart acknowledges it. A start pulse launches the program buffer, and the block then waits for a done strobe, which may carry an exception flag. The debugger sees a busy flag and a sticky three-bit error code. An auto-execute enable makes every access to data register 0 run the last accepted command again, so a block of memory can be streamed through data register 0 without rewriting the command.

Top module: `abscmd_engine`

## Requirements
- R1: After reset `busy`, `cmderr`, `data0_q`, `hreg_req` and `pb_start` are all zero, and auto-execute is disabled.
- R2: The command word has these fields: kind in bits 31:24 (0 = register access), reserved bit 23, size in bits 22:20, reserved bit 19, postexec in bit 18, transfer in bit 17, write in bit 16 and register number in bits 15:0. An accepted command with transfer=1 and write=1 raises `hreg_req` with `hreg_we`=1, `hreg_addr` equal to the register number and `hreg_wdata` equal to data register 0. These values are held unchanged until the cycle in which `hreg_ack` is seen.
- R3: A transfer with write=0 issues a request with `hreg_we`=0 and loads `hreg_rdata` into `data0_q` on the acknowledge edge.
- R4: With postexec=1, `pb_start` pulses for exactly one cycle after the transfer completes, and the command stays busy until `pb_done`. A command with postexec=1 and transfer=0 runs the buffer and makes no hart register request.
- R5: Register numbers 0x1000–0x101F (0x1008 = s0, 0x1009 = s1) and 0x300 (mstatus) are supported, with size code 2 (32 bits) only. A nonzero kind, a nonzero reserved bit, or a transfer with any other size or register number sets `cmderr`=2 and starts nothing. With transfer=0, the size and register number are not checked.
- R6: `pb_exc` together with `pb_done` sets `cmderr`=3.
- R7: `busy` rises in the cycle after a command is accepted and falls in the cycle after the final acknowledge, or after `pb_done` when the buffer runs.
- R8: A command write, or an auto-execute trigger, that arrives while busy sets `cmderr`=1 and is not run. A data register 0 write that arrives while busy is discarded.
- R9: `cmderr` is sticky. Writing `err_clr_wr` clears exactly the bits set in `err_clr_mask`. While `cmderr` is nonzero, command writes and auto-execute triggers are ignored and the stored command is kept. A new error code is recorded only when the field is zero; if codes arise in the same cycle, 3 beats 2, which beats 1.
- R10: With auto-execute enabled (`auto_wdata`=1 latched by `auto_wr`), a read or write of data register 0 while idle and error-free runs the last accepted command again. On a write, the command uses the newly written value. With auto-execute disabled, data register 0 accesses start nothing.
- R11: `hreg_req` and `pb_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| data0_wr | input | 1 | Data register 0 write strobe |
| data0_rd | input | 1 | Data register 0 read strobe (auto-execute trigger) |
| data0_wdata | input | DATA_W | Data register 0 write value |
| data0_q | output | DATA_W | Data register 0 contents |
| auto_wr | input | 1 | Auto-execute enable write strobe |
| auto_wdata | input | 1 | New auto-execute enable |
| err_clr_wr | input | 1 | Error clear strobe |
| err_clr_mask | input | 3 | Bits of the error code to clear |
| busy | output | 1 | Command in progress |
| cmderr | output | 3 | Sticky error code (0 none, 1 busy, 2 not supported, 3 exception) |
| hreg_req | output | 1 | Hart register access request |
| hreg_we | output | 1 | Request direction, 1 = write hart register |
| hreg_addr | output | 16 | Hart register number |
| hreg_wdata | output | DATA_W | Value written to the hart register |
| hreg_rdata | input | DATA_W | Value read from the hart register |
| hreg_ack | input | 1 | Hart acknowledges the request |
| pb_start | output | 1 | One-cycle program buffer start |
| pb_done | input | 1 | Program buffer finished |
| pb_exc | input | 1 | Program buffer raised an exception (valid with pb_done) |

## Verification
The assertions assume that the hart raises `hreg_ack` only while `hreg_req` is high, and for one cycle per request. They also assume that `pb_done` and `pb_exc` come only after a `pb_start` and before the next one, and that no error clear falls in the same cycle as a fault being recorded. The bench responder keeps these rules by construction: it acknowledges one cycle after it sees a new request and finishes the buffer a fixed three cycles after the start pulse. The stimulus never clears the error field in a cycle where a fault can arise, and it drives at most one host strobe per cycle, except for the deliberate overlap of an auto-execute data write.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

    typedef struct packed {
        logic [7:0]  kind;
        logic        rsvd_a;
        logic [2:0]  size;
        logic        rsvd_b;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } cmd_word_t;

    typedef struct packed {
        logic legal;
        logic go_xfer;
        logic go_pb;
    } cmd_plan_t;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_UNSUP  = 3'd2,
        ERR_EXCEPT = 3'd3
    } cmderr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PB_GO,
        ST_PB_WAIT
    } seq_state_e;

    localparam logic [7:0] KIND_REGACC = 8'd0;

    function automatic logic [2:0] size_code(input int unsigned width);
        return 3'($clog2(width / 8));
    endfunction

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
    import abscmd_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [15:0] GPR_BASE  = 16'h1000,
    parameter int unsigned GPR_COUNT = 32,
    parameter logic [15:0] CSR_SEL   = 16'h0300
) (
    input  cmd_word_t cmd,
    output cmd_plan_t plan
);
    localparam logic [2:0]  SIZE_OK = size_code(DATA_W);
    localparam logic [16:0] GPR_END = {1'b0, GPR_BASE} + 17'(GPR_COUNT);

    logic reg_ok;
    logic shape_ok;
    logic xfer_ok;

    always_comb begin
        reg_ok   = (({1'b0, cmd.regno} >= {1'b0, GPR_BASE}) &&
                    ({1'b0, cmd.regno} <  GPR_END)) ||
                   (cmd.regno == CSR_SEL);
        shape_ok = (cmd.kind == KIND_REGACC) && !cmd.rsvd_a && !cmd.rsvd_b;
        xfer_ok  = !cmd.transfer || ((cmd.size == SIZE_OK) && reg_ok);
        plan.legal   = shape_ok && xfer_ok;
        plan.go_xfer = cmd.transfer;
        plan.go_pb   = cmd.postexec;
    end

endmodule

// File: rtl/abscmd_seq.sv
module abscmd_seq
    import abscmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      launch,
    input  cmd_plan_t plan,
    input  logic      hreg_ack,
    input  logic      pb_done,
    input  logic      pb_exc,
    output logic      busy,
    output logic      hreg_req,
    output logic      pb_start,
    output logic      exc_hit
);
    seq_state_e state_q, state_d;
    logic       post_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    if (plan.go_xfer)    state_d = ST_XFER;
                    else if (plan.go_pb) state_d = ST_PB_GO;
                end
            end
            ST_XFER:    if (hreg_ack) state_d = post_q ? ST_PB_GO : ST_IDLE;
            ST_PB_GO:   state_d = ST_PB_WAIT;
            ST_PB_WAIT: if (pb_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            post_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch && state_q == ST_IDLE) post_q <= plan.go_pb;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign hreg_req = (state_q == ST_XFER);
    assign pb_start = (state_q == ST_PB_GO);
    assign exc_hit  = (state_q == ST_PB_WAIT) && pb_done && pb_exc;

    AST_PB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pb_start |=> !pb_start); // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hreg_req && pb_start)); // R11

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (busy && !hreg_req && !pb_start && pb_done) |=> !busy); // R7

endmodule

// File: rtl/abscmd_err.sv
module abscmd_err
    import abscmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_wr,
    input  logic [2:0] clr_mask,
    input  logic       set_busy,
    input  logic       set_unsup,
    input  logic       set_exc,
    output logic [2:0] err
);
    cmderr_e   err_q;
    logic [2:0] kept;
    cmderr_e   code;

    always_comb begin
        kept = clr_wr ? (err_q & ~clr_mask) : err_q;
        if (set_exc)        code = ERR_EXCEPT;
        else if (set_unsup) code = ERR_UNSUP;
        else if (set_busy)  code = ERR_BUSY;
        else                code = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= ERR_NONE;
        end else if (kept == 3'd0 && code != ERR_NONE) begin
            err_q <= code;
        end else begin
            err_q <= cmderr_e'(kept);
        end
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err != 3'd0 && !clr_wr) |=> (err == $past(err))); // R9

endmodule

// File: rtl/abscmd_engine.sv
module abscmd_engine
    import abscmd_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [15:0] GPR_BASE  = 16'h1000,
    parameter int unsigned GPR_COUNT = 32,
    parameter logic [15:0] CSR_SEL   = 16'h0300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              data0_wr,
    input  logic              data0_rd,
    input  logic [DATA_W-1:0] data0_wdata,
    output logic [DATA_W-1:0] data0_q,
    input  logic              auto_wr,
    input  logic              auto_wdata,
    input  logic              err_clr_wr,
    input  logic [2:0]        err_clr_mask,
    output logic              busy,
    output logic [2:0]        cmderr,
    output logic              hreg_req,
    output logic              hreg_we,
    output logic [15:0]       hreg_addr,
    output logic [DATA_W-1:0] hreg_wdata,
    input  logic [DATA_W-1:0] hreg_rdata,
    input  logic              hreg_ack,
    output logic              pb_start,
    input  logic              pb_done,
    input  logic              pb_exc
);
    cmd_word_t last_q;
    cmd_word_t cand;
    cmd_plan_t plan;
    logic      auto_q;
    logic      trig_auto;
    logic      trig_any;
    logic      may_run;
    logic      launch;
    logic      set_unsup;
    logic      set_busy;
    logic      exc_hit;

    always_comb begin
        trig_auto = auto_q && (data0_wr || data0_rd);
        trig_any  = cmd_wr || trig_auto;
        cand      = cmd_wr ? cmd_word_t'(cmd_wdata) : last_q;
        may_run   = trig_any && !busy && (cmderr == 3'd0);
        launch    = may_run && plan.legal && (plan.go_xfer || plan.go_pb);
        set_unsup = may_run && !plan.legal;
        set_busy  = trig_any && busy;
    end

    abscmd_decode #(
        .DATA_W    (DATA_W),
        .GPR_BASE  (GPR_BASE),
        .GPR_COUNT (GPR_COUNT),
        .CSR_SEL   (CSR_SEL)
    ) u_decode (
        .cmd  (cand),
        .plan (plan)
    );

    abscmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .plan     (plan),
        .hreg_ack (hreg_ack),
        .pb_done  (pb_done),
        .pb_exc   (pb_exc),
        .busy     (busy),
        .hreg_req (hreg_req),
        .pb_start (pb_start),
        .exc_hit  (exc_hit)
    );

    abscmd_err u_err (
        .clk       (clk),
        .rst       (rst),
        .clr_wr    (err_clr_wr),
        .clr_mask  (err_clr_mask),
        .set_busy  (set_busy),
        .set_unsup (set_unsup),
        .set_exc   (exc_hit),
        .err       (cmderr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            auto_q  <= 1'b0;
            data0_q <= '0;
        end else begin
            if (cmd_wr && !busy && cmderr == 3'd0) last_q <= cmd_word_t'(cmd_wdata);
            if (auto_wr) auto_q <= auto_wdata;
            if (hreg_req && hreg_ack && !last_q.write) begin
                data0_q <= hreg_rdata;
            end else if (data0_wr && !busy) begin
                data0_q <= data0_wdata;
            end
        end
    end

    assign hreg_we    = last_q.write;
    assign hreg_addr  = last_q.regno;
    assign hreg_wdata = data0_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hreg_req && !hreg_ack) |=> (hreg_req && $stable(hreg_addr) &&
                                     $stable(hreg_we) && $stable(hreg_wdata))); // R2

    AST_READ_LANDS: assert property (@(posedge clk) disable iff (rst)
        (hreg_req && hreg_ack && !hreg_we) |=> (data0_q == $past(hreg_rdata))); // R3

    AST_BUSY_FAULT: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr && cmderr == 3'd0 && !(pb_done && pb_exc)) |=> (cmderr == 3'd1)); // R8

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmderr != 3'd0) |=> !busy); // R9

endmodule

// File: tb/tb_abscmd_engine.sv
module tb_abscmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PB_LAT     = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        data0_wr = 1'b0;
    logic        data0_rd = 1'b0;
    logic [31:0] data0_wdata = '0;
    logic [31:0] data0_q;
    logic        auto_wr = 1'b0;
    logic        auto_wdata = 1'b0;
    logic        err_clr_wr = 1'b0;
    logic [2:0]  err_clr_mask = '0;
    logic        busy;
    logic [2:0]  cmderr;
    logic        hreg_req;
    logic        hreg_we;
    logic [15:0] hreg_addr;
    logic [31:0] hreg_wdata;
    logic [31:0] hreg_rdata;
    logic        hreg_ack;
    logic        pb_start;
    logic        pb_done;
    logic        pb_exc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    abscmd_engine dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .data0_wr(data0_wr), .data0_rd(data0_rd), .data0_wdata(data0_wdata),
        .data0_q(data0_q), .auto_wr(auto_wr), .auto_wdata(auto_wdata),
        .err_clr_wr(err_clr_wr), .err_clr_mask(err_clr_mask), .busy(busy),
        .cmderr(cmderr), .hreg_req(hreg_req), .hreg_we(hreg_we),
        .hreg_addr(hreg_addr), .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata),
        .hreg_ack(hreg_ack), .pb_start(pb_start), .pb_done(pb_done), .pb_exc(pb_exc)
    );

    // ---------------- hart responder ----------------
    logic [31:0] gpr [32];
    logic [31:0] csr_status;
    int          pb_left;
    bit          pb_fail = 0;
    bit          poke_en = 0;
    int          poke_idx = 0;
    logic [31:0] poke_val = '0;
    int          xfer_cnt = 0;
    int          pb_cnt = 0;
    int          overlap_cnt = 0;

    assign pb_exc = pb_done && pb_fail;

    always @(posedge clk) begin
        if (rst) begin
            hreg_ack   <= 1'b0;
            hreg_rdata <= '0;
            pb_done    <= 1'b0;
            pb_left    <= 0;
            csr_status <= '0;
            for (int i = 0; i < 32; i++) gpr[i] <= '0;
        end else begin
            hreg_ack <= hreg_req && !hreg_ack;
            if (hreg_req && !hreg_ack) begin
                if (hreg_addr >= 16'h1000 && hreg_addr < 16'h1020) begin
                    if (hreg_we) gpr[hreg_addr[4:0]] <= hreg_wdata;
                    hreg_rdata <= gpr[hreg_addr[4:0]];
                end else begin
                    if (hreg_we) csr_status <= hreg_wdata;
                    hreg_rdata <= csr_status;
                end
            end
            if (poke_en) gpr[poke_idx] <= poke_val;
            pb_done <= 1'b0;
            if (pb_start) pb_left <= PB_LAT;
            else if (pb_left != 0) begin
                pb_left <= pb_left - 1;
                if (pb_left == 1) pb_done <= 1'b1;
            end
            if (hreg_req && hreg_ack) xfer_cnt <= xfer_cnt + 1;
            if (pb_start) pb_cnt <= pb_cnt + 1;
            if (pb_start && hreg_req) overlap_cnt <= overlap_cnt + 1;
        end
    end

    // ---------------- behavioural reference model ----------------
    int          m_phase;   // 0 idle, 1 transfer, 2 start pulse, 3 buffer running
    int          m_err;
    logic [31:0] m_data0;
    logic [31:0] m_last;
    bit          m_auto;

    function automatic bit legal(input logic [31:0] w);
        int rn;
        rn = int'(w[15:0]);
        if (w[31:24] != 0 || w[23] || w[19]) return 0;
        if (!w[17]) return 1;
        return (w[22:20] == 3'd2) && ((rn >= 32'h1000 && rn < 32'h1020) || rn == 32'h300);
    endfunction

    always @(posedge clk) begin
        int          e;
        int          setcode;
        bit          trig;
        logic [31:0] w;
        if (rst) begin
            m_phase = 0; m_err = 0; m_data0 = '0; m_last = '0; m_auto = 0;
        end else begin
            e = m_err;
            if (err_clr_wr) e = e & ~int'(err_clr_mask);
            setcode = 0;
            trig = cmd_wr || (m_auto && (data0_wr || data0_rd));
            if (m_phase != 0) begin
                if (trig) setcode = 1;
                case (m_phase)
                    1: if (hreg_ack) begin
                           if (!m_last[16]) m_data0 = hreg_rdata;
                           m_phase = m_last[18] ? 2 : 0;
                       end
                    2: m_phase = 3;
                    default: if (pb_done) begin
                           if (pb_exc) setcode = 3;
                           m_phase = 0;
                       end
                endcase
            end else begin
                if (trig && m_err == 0) begin
                    w = cmd_wr ? cmd_wdata : m_last;
                    if (cmd_wr) m_last = cmd_wdata;
                    if (!legal(w)) setcode = 2;
                    else if (w[17]) m_phase = 1;
                    else if (w[18]) m_phase = 2;
                end
                if (data0_wr) m_data0 = data0_wdata;
            end
            if (e == 0 && setcode != 0) e = setcode;
            m_err = e;
            if (auto_wr) m_auto = auto_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R7 busy vs model", 32'(busy), 32'(m_phase != 0));
            chk("R9 cmderr vs model", 32'(cmderr), 32'(m_err));
            chk("R3 data0 vs model", data0_q, m_data0);
            chk("R2 hreg_req vs model", 32'(hreg_req), 32'(m_phase == 1));
            chk("R4 pb_start vs model", 32'(pb_start), 32'(m_phase == 2));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk(input int kind, input int size, input bit post,
                                       input bit xfer, input bit wr, input int regno);
        return {8'(kind), 1'b0, 3'(size), 1'b0, post, xfer, wr, 16'(regno)};
    endfunction

    task automatic put_cmd(input logic [31:0] w);
        cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic put_data0(input logic [31:0] v);
        data0_wr = 1'b1; data0_wdata = v;
        @(negedge clk);
        data0_wr = 1'b0;
    endtask

    task automatic get_data0;
        data0_rd = 1'b1;
        @(negedge clk);
        data0_rd = 1'b0;
    endtask

    task automatic set_auto(input bit v);
        auto_wr = 1'b1; auto_wdata = v;
        @(negedge clk);
        auto_wr = 1'b0;
    endtask

    task automatic clr_err(input logic [2:0] m);
        err_clr_wr = 1'b1; err_clr_mask = m;
        @(negedge clk);
        err_clr_wr = 1'b0;
    endtask

    task automatic poke(input int idx, input logic [31:0] v);
        poke_en = 1'b1; poke_idx = idx; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_idle;
        for (int n = 0; n < 50 && busy; n++) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int x0;
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1;
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 cmderr after reset", 32'(cmderr), 0);
        chk("R1 data0 after reset", data0_q, 0);
        chk("R1 no request after reset", 32'(hreg_req | pb_start), 0);

        // R2: write s0 from data0
        put_data0(32'hA5A5_0001);
        put_cmd(mk(0, 2, 0, 1, 1, 'h1008));
        chk("R7 busy right after accept", 32'(busy), 1);
        wait_idle();
        chk("R2 s0 written", gpr[8], 32'hA5A5_0001);

        // R3: read s1 into data0
        poke(9, 32'h1234_5678);
        put_cmd(mk(0, 2, 0, 1, 0, 'h1009));
        wait_idle();
        chk("R3 data0 from s1", data0_q, 32'h1234_5678);

        // R2: write mstatus
        put_data0(32'hDEAD_0300);
        put_cmd(mk(0, 2, 0, 1, 1, 'h300));
        wait_idle();
        chk("R2 mstatus written", csr_status, 32'hDEAD_0300);

        // R4: transfer then program buffer
        p0 = pb_cnt; x0 = xfer_cnt;
        put_cmd(mk(0, 2, 1, 1, 0, 'h1008));
        wait_idle();
        chk("R4 buffer ran after transfer", 32'(pb_cnt - p0), 1);
        chk("R4 transfer done first", 32'(xfer_cnt - x0), 1);
        chk("R3 data0 from s0", data0_q, 32'hA5A5_0001);

        // R4: postexec only
        p0 = pb_cnt; x0 = xfer_cnt;
        put_cmd(mk(0, 0, 1, 0, 0, 'h7777));
        wait_idle();
        chk("R4 buffer only run", 32'(pb_cnt - p0), 1);
        chk("R4 no transfer for buffer only", 32'(xfer_cnt - x0), 0);
        chk("R5 no error when transfer clear", 32'(cmderr), 0);

        // R5: unsupported forms
        x0 = xfer_cnt;
        put_cmd(mk(0, 3, 0, 1, 1, 'h1008));
        @(negedge clk);
        chk("R5 bad size code", 32'(cmderr), 2);
        chk("R5 bad size no transfer", 32'(xfer_cnt - x0), 0);
        chk("R5 bad size not busy", 32'(busy), 0);
        // R9: partial clear keeps remaining bits
        clr_err(3'b001);
        chk("R9 partial clear", 32'(cmderr), 2);
        // R9: ignored while error set
        put_cmd(mk(0, 2, 0, 1, 1, 'h1009));
        chk("R9 command ignored on error", 32'(busy), 0);
        clr_err(3'b111);
        chk("R9 full clear", 32'(cmderr), 0);
        put_cmd(mk(0, 2, 0, 1, 1, 'h2000));
        @(negedge clk);
        chk("R5 bad register number", 32'(cmderr), 2);
        clr_err(3'b111);
        put_cmd(mk(1, 2, 0, 1, 1, 'h1008));
        @(negedge clk);
        chk("R5 bad kind", 32'(cmderr), 2);
        clr_err(3'b111);
        chk("R5 no transfer for rejected", 32'(xfer_cnt - x0), 0);

        // R8: command while busy
        p0 = pb_cnt;
        put_cmd(mk(0, 0, 1, 0, 0, 0));
        put_cmd(mk(0, 2, 0, 1, 1, 'h1008));
        chk("R8 busy error code", 32'(cmderr), 1);
        wait_idle();
        chk("R8 second command not run", 32'(pb_cnt - p0), 1);
        clr_err(3'b111);
        // R8: data0 write while busy dropped
        put_data0(32'h0000_BEEF);
        put_cmd(mk(0, 0, 1, 0, 0, 0));
        put_data0(32'hFFFF_0000);
        wait_idle();
        chk("R8 data0 write while busy dropped", data0_q, 32'h0000_BEEF);

        // R6: exception in buffer
        pb_fail = 1;
        put_cmd(mk(0, 0, 1, 0, 0, 0));
        wait_idle();
        chk("R6 exception code", 32'(cmderr), 3);
        pb_fail = 0;
        clr_err(3'b111);

        // R10: auto-execute on write
        put_cmd(mk(0, 2, 0, 1, 1, 'h1008));
        wait_idle();
        set_auto(1);
        put_data0(32'h1111_2222);
        wait_idle();
        chk("R10 replay uses new data0", gpr[8], 32'h1111_2222);
        put_data0(32'h3333_4444);
        wait_idle();
        chk("R10 second replay", gpr[8], 32'h3333_4444);
        // R10: auto-execute on read
        set_auto(0);
        put_cmd(mk(0, 2, 0, 1, 0, 'h1009));
        wait_idle();
        poke(9, 32'h5555_6666);
        set_auto(1);
        get_data0();
        wait_idle();
        chk("R10 read replay", data0_q, 32'h5555_6666);
        // R10: disabled stops replay
        set_auto(0);
        x0 = xfer_cnt;
        put_data0(32'h7777_8888);
        get_data0();
        wait_idle();
        chk("R10 no replay when off", 32'(xfer_cnt - x0), 0);
        chk("R10 data0 kept", data0_q, 32'h7777_8888);

        chk("R11 no overlap seen", 32'(overlap_cnt), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule